// File: doc/BRIEF.md
# Rounding Average and Absolute Difference ALU

This block is a single-slice arithmetic unit for media and motion-search kernels. It takes two operands, `opa` and `opb`, plus an accumulator input `acc_in`. A 3-bit operation code selects one of five functions:

- an unsigned average that rounds up;
- a signed absolute difference;
- an unsigned absolute difference;
- signed and unsigned absolute-difference-accumulate, which add the difference to `acc_in`.

By default the result is captured in one output register. That register is cleared by a synchronous active-low reset.

A sum-of-absolute-differences chain is built by routing `result` back to `acc_in`. The next pair of samples is presented each cycle, and each step adds one difference to the running total. All arithmetic wraps modulo 2^W. The average is the one exception: it keeps the carry out of the W+1-bit sum before halving.

Top module: `avgabs_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` becomes zero at that edge.
- R2: Code 0 (average) yields floor((opa + opb + 1) / 2), evaluated over W+1 bits so the carry is kept. Example: 0xc523e996a8ff6215 with 0xe1e5b9cc9864c4a8 gives 0xd384d1b1a0b2135f. If the first operand ends in 4 or 3 instead, the result is 0xd384d1b1a0b2135e.
- R3: The average of two all-ones operands is all-ones, and an average never lies outside the unsigned range spanned by its two operands.
- R4: Code 1 (signed absolute difference) treats both operands as two's complement and subtracts the smaller from the larger. Example: all-ones with 2 gives 3.
- R5: Code 2 (unsigned absolute difference) subtracts the unsigned smaller operand from the larger. Example: all-ones with 2 gives 0xfffffffffffffffd.
- R6: Both absolute differences are symmetric: swapping `opa` and `opb` gives the same result. Example: (1,2) and (2,1) both give 1.
- R7: Code 3 (signed accumulate) yields `acc_in` plus the signed absolute difference, modulo 2^W. Starting from 0, the steps (2, all-ones) then (9,3) end at 9.
- R8: Code 4 (unsigned accumulate) yields `acc_in` plus the unsigned absolute difference, modulo 2^W. Starting from 0, the steps (2,1) then (9,3) end at 7. The steps (2, all-ones) then (9,3) end at 3.
- R9: Codes 5, 6 and 7 yield zero.
- R10: With the output register enabled, the value selected by the inputs sampled at one rising edge appears on `result` right after that edge, and a new operation is accepted at every edge.
- R11: Equal operands give a zero absolute difference, and the accumulate forms then return `acc_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Operation code: 0 avg, 1 signed diff, 2 unsigned diff, 3 signed accumulate, 4 unsigned accumulate |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| acc_in | input | W | Accumulator input for codes 3 and 4 |
| result | output | W | Selected result, registered by default |

## Verification
The interaction that matters is an accumulate step that consumes the result of the previous cycle while a different operation is issued around it. The output register is then both the destination of one function and the source of the next. The bench provokes this with back-to-back accumulate chains that feed `result` into `acc_in`. It interleaves averages, plain differences and unused codes between the accumulate steps, and flips the signedness from one step to the next. A behavioural model predicts the value after every edge and checks it on every clock. Its arithmetic uses wide integer sums and explicit signed comparisons.

// File: rtl/avgabs_pkg.sv
// Package: shared operation encoding for the average / absolute-difference ALU.
// Assumes: the 3-bit code is decoded in one place (the top module).
package avgabs_pkg;
    typedef enum logic [2:0] {
        OP_AVG   = 3'd0,
        OP_ABSDS = 3'd1,
        OP_ABSDU = 3'd2,
        OP_ACCS  = 3'd3,
        OP_ACCU  = 3'd4
    } alu_op_e;

    localparam int unsigned OP_CODE_BITS = 3;
endpackage

// File: rtl/avgabs_rnd_avg.sv
// Module: rounding-up unsigned average of two W-bit operands.
// Assumes: operands are unsigned. The sum is built over W+1 bits so the
// carry survives before the halving shift.
module avgabs_rnd_avg #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] avg
);
    localparam int unsigned SW = W + 1;

    logic [SW-1:0] sum_wide;

    // Purpose: wide sum plus rounding increment, then drop the low bit.
    always_comb begin
        sum_wide = {1'b0, a} + {1'b0, b} + {{(SW-1){1'b0}}, 1'b1};
        avg      = sum_wide[SW-1:1];
    end
endmodule

// File: rtl/avgabs_abs_diff.sv
// Module: absolute difference, larger operand minus smaller operand.
// Assumes: is_signed selects two's-complement ordering; the result is the
// modular W-bit difference, so it may exceed the signed range.
module avgabs_abs_diff #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    output logic [W-1:0] diff,
    output logic         a_below
);
    logic [W-1:0] a_key;
    logic [W-1:0] b_key;

    // Purpose: map signed ordering onto unsigned ordering by flipping the MSB.
    always_comb begin
        a_key = {a[W-1] ^ is_signed, a[W-2:0]};
        b_key = {b[W-1] ^ is_signed, b[W-2:0]};
    end

    // Purpose: compare once, then subtract the smaller from the larger.
    always_comb begin
        a_below = (a_key < b_key);
        diff    = a_below ? (b - a) : (a - b);
    end
endmodule

// File: rtl/avgabs_out_stage.sv
// Module: optional output register with synchronous active-low clear.
// Assumes: OUT_REG=0 gives a pure wire and the clock and reset are unused.
module avgabs_out_stage #(
    parameter int unsigned W       = 64,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (OUT_REG) begin : g_reg
            logic [W-1:0] q_r;
            // Purpose: capture the selected result, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_wire
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/avgabs_alu.sv
// Module: top of the rounding average / absolute difference ALU slice.
// Assumes: op_sel follows avgabs_pkg::alu_op_e and unused codes give zero.
// For sum-of-absolute-differences chains the caller feeds result back into
// acc_in; the register sits in the output stage.
module avgabs_alu #(
    parameter int unsigned W       = 64,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] acc_in,
    output logic [W-1:0] result
);
    import avgabs_pkg::*;

    logic [W-1:0] avg_val;
    logic [W-1:0] diff_s;
    logic [W-1:0] diff_u;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] next_val;

    avgabs_rnd_avg #(.W(W)) u_avg (
        .a   (opa),
        .b   (opb),
        .avg (avg_val)
    );

    avgabs_abs_diff #(.W(W)) u_diff_s (
        .a         (opa),
        .b         (opb),
        .is_signed (1'b1),
        .diff      (diff_s),
        .a_below   (lt_s)
    );

    avgabs_abs_diff #(.W(W)) u_diff_u (
        .a         (opa),
        .b         (opb),
        .is_signed (1'b0),
        .diff      (diff_u),
        .a_below   (lt_u)
    );

    // Purpose: select the function named by the operation code.
    always_comb begin
        case (alu_op_e'(op_sel))
            OP_AVG:   next_val = avg_val;
            OP_ABSDS: next_val = diff_s;
            OP_ABSDU: next_val = diff_u;
            OP_ACCS:  next_val = acc_in + diff_s;
            OP_ACCU:  next_val = acc_in + diff_u;
            default:  next_val = '0;
        endcase
    end

    avgabs_out_stage #(.W(W), .OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_val),
        .q     (result)
    );

    generate
        if (OUT_REG) begin : g_chk
            logic unused_lt;
            assign unused_lt = lt_s ^ lt_u;

            // R9: unused operation codes give zero one cycle later
            p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (op_sel > 3'd4) |=> (result == '0));

            // R3: the average lies within the unsigned span of its operands
            p_avg_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (op_sel == 3'd0) |=>
                    ((result >= ($past(opa) < $past(opb) ? $past(opa) : $past(opb))) &&
                     (result <= ($past(opa) < $past(opb) ? $past(opb) : $past(opa)))));

            // R3: the average of two all-ones operands is all-ones
            p_avg_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (op_sel == 3'd0 && (&opa) && (&opb)) |=> (&result));

            // R11: equal operands give zero difference
            p_equal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
                ((op_sel == 3'd1 || op_sel == 3'd2) && opa == opb) |=> (result == '0));

            // R8: unsigned accumulate adds the unsigned difference to acc_in
            p_accu_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (op_sel == 3'd4) |=> (result == $past(acc_in + diff_u)));

            // R7: signed accumulate adds the signed difference to acc_in
            p_accs_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (op_sel == 3'd3) |=> (result == $past(acc_in + diff_s)));

            // R10: plain differences appear one edge after issue
            p_absdu_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (op_sel == 3'd2) |=> (result == $past(diff_u)));
        end
    endgenerate
endmodule

// File: tb/avgabs_alu_bench.sv
// Bench: behavioural model of the ALU, compared after every clock edge.
module avgabs_alu_bench;
    localparam int W = 64;
    localparam logic [63:0] ONES = 64'hffff_ffff_ffff_ffff;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_sel = 3'd0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [W-1:0]  acc_in = '0;
    logic [W-1:0]  result;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    avgabs_alu #(.W(W), .OUT_REG(1'b1)) u_avgabs_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_sel (op_sel),
        .opa    (opa),
        .opb    (opb),
        .acc_in (acc_in),
        .result (result)
    );

    function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] rt);
        logic [64:0] s;
        logic [63:0] ds, du;
        s  = 65'(a) + 65'(b) + 65'd1;
        ds = ($signed(a) > $signed(b)) ? a - b : b - a;
        du = (a > b) ? a - b : b - a;
        case (op)
            3'd0: return s[64:1];
            3'd1: return ds;
            3'd2: return du;
            3'd3: return rt + ds;
            3'd4: return rt + du;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", tag, result, exp);
        end
    endtask

    // issue one operation at the falling edge, sample one ns after the rising edge
    task automatic step(input string tag, input logic [2:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] rt);
        logic [63:0] exp;
        @(negedge clk);
        op_sel = op; opa = a; opb = b; acc_in = rt;
        exp = model(op, a, b, rt);
        @(posedge clk);
        #1;
        check(tag, exp);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: result=%h expected=completion", result);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] acc;
        // R1: reset clears the register
        op_sel = 3'd1; opa = 64'd50; opb = 64'd7;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 examples
        step("R2 avg", 3'd0, 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 0);
        step("R2 avg lsb4", 3'd0, 64'hc523e996a8ff6214, 64'he1e5b9cc9864c4a8, 0);
        step("R2 avg lsb3", 3'd0, 64'hc523e996a8ff6213, 64'he1e5b9cc9864c4a8, 0);
        checks++;
        if (result !== 64'hd384d1b1a0b2135e) begin
            errors++;
            $display("FAIL R2 literal: result=%h expected=%h", result, 64'hd384d1b1a0b2135e);
        end
        // R3
        step("R3 avg ones", 3'd0, ONES, ONES, 0);
        checks++;
        if (result !== ONES) begin
            errors++;
            $display("FAIL R3 literal: result=%h expected=%h", result, ONES);
        end
        // R4 / R5 / R6
        step("R4 absds", 3'd1, ONES, 64'd2, 0);
        checks++;
        if (result !== 64'd3) begin
            errors++;
            $display("FAIL R4 literal: result=%h expected=%h", result, 64'd3);
        end
        step("R5 absdu", 3'd2, ONES, 64'd2, 0);
        checks++;
        if (result !== 64'hfffffffffffffffd) begin
            errors++;
            $display("FAIL R5 literal: result=%h expected=%h", result, 64'hfffffffffffffffd);
        end
        step("R6 swap u", 3'd2, 64'd2, ONES, 0);
        step("R6 absds 1,2", 3'd1, 64'd1, 64'd2, 0);
        step("R6 absds 2,1", 3'd1, 64'd2, 64'd1, 0);
        step("R6 absdu 1,2", 3'd2, 64'd1, 64'd2, 0);
        step("R11 equal", 3'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0);
        step("R11 acc equal", 3'd4, 64'd77, 64'd77, 64'h1234);

        // R8: chain (2,1),(9,3) -> 7, fed back through result
        step("R8 chain a1", 3'd4, 64'd2, 64'd1, 0);
        step("R8 chain a2", 3'd4, 64'd9, 64'd3, result);
        checks++;
        if (result !== 64'd7) begin
            errors++;
            $display("FAIL R8 chain: result=%h expected=%h", result, 64'd7);
        end
        step("R8 chain b1", 3'd4, 64'd2, ONES, 0);
        step("R8 chain b2", 3'd4, 64'd9, 64'd3, result);
        checks++;
        if (result !== 64'd3) begin
            errors++;
            $display("FAIL R8 wrap chain: result=%h expected=%h", result, 64'd3);
        end
        // R7
        step("R7 chain 1", 3'd3, 64'd2, ONES, 0);
        step("R7 chain 2", 3'd3, 64'd9, 64'd3, result);
        checks++;
        if (result !== 64'd9) begin
            errors++;
            $display("FAIL R7 chain: result=%h expected=%h", result, 64'd9);
        end
        // R9
        for (int c = 5; c < 8; c++) step("R9 unused", 3'(c), ONES, 64'd5, ONES);

        // R10: random back-to-back mix with feedback chains
        acc = 0;
        for (int i = 0; i < 2000; i++) begin
            logic [2:0] op;
            logic [63:0] a, b;
            op = 3'($urandom_range(0, 7));
            a = {$urandom, $urandom};
            b = ($urandom_range(0, 7) == 0) ? a : {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) a = a >> $urandom_range(0, 63);
            acc = ($urandom_range(0, 3) != 0) ? result : {$urandom, $urandom};
            step("R10 random", op, a, b, acc);
        end

        // R1: reset in mid-stream
        @(negedge clk);
        rst_n = 1'b0; op_sel = 3'd4; opa = 64'd9; opb = 64'd1; acc_in = ONES;
        @(posedge clk);
        #1;
        check("R1 mid reset", 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule